// File: doc/BRIEF.md
# Reaction Time Tester

This block measures how quickly a person responds to a light. Pulling the arm input low starts a waiting period and clears the result. The length of the wait is taken from an 8-bit selector and counts in steps of a fixed number of milliseconds. When the wait runs out, the lamp output turns on and a four-digit decimal counter starts stepping once per millisecond. When the subject pulls the stop input low, the lamp turns off and the counter freezes, holding the reaction time.

The lowest digits of the held result drive active-low seven-segment outputs. The block also exposes the full binary-coded-decimal value. A free-running system clock feeds two dividers. The first divides the clock down to a millisecond tick. The second counts those ticks against the selector to time the wait. Every output comes straight from a register on the system clock. Switch debouncing and random delays are left to the logic around the block.

Top module: `reaction_timer`

## Requirements
- R1: While rst_n is low, lamp is 0 and count_bcd is 0. Every displayed digit shows the pattern for zero, which is 7'h40.
- R2: When arm_n is sampled low in any state, the next edge clears count_bcd to 0, turns lamp off and starts a new wait. An arm press wins over a stop press in the same cycle.
- R3: Let k = max(1, wait_sel*WAIT_UNIT_MS). Lamp rises exactly k*MS_DIV clock edges after the edge that sampled the arm press. This also holds for wait_sel = 0, where k = 1.
- R4: A stop press during the wait neither shortens nor cancels it. The lamp still rises at the time given in R3.
- R5: While the lamp is on, count_bcd goes up by one every MS_DIV edges. The first increment comes MS_DIV edges after the lamp rises.
- R6: When stop_n is sampled low while the lamp is on, the next edge turns the lamp off. From then on count_bcd holds, and a millisecond tick in the same cycle does not advance it.
- R7: After a stop, count_bcd and lamp do not change, even with more stop presses, until the next arm press.
- R8: The counter stops at 9999 and never wraps to 0.
- R9: seg_n[7*i+6 : 7*i] shows decimal digit i of count_bcd, with i = 0 being the least significant digit. Within each digit, bit 0 is segment a and bit 6 is segment g, and a segment is lit when its bit is 0. The digit codes are 0:40, 1:79, 2:24, 3:30, 4:19, 5:12, 6:02, 7:78, 8:00 and 9:10 (hex). The display changes in the same cycle as count_bcd.
- R10: Each 4-bit digit of count_bcd holds a value from 0 to 9, with the least significant digit in bits 3:0. A digit steps from 9 back to 0 and carries one into the next digit.
- R11: After reset and before the first arm press, the block stays idle. The lamp is off and the count stays 0, whatever happens on stop_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arm_n | input | 1 | Arm button, active low |
| stop_n | input | 1 | Stop button, active low |
| wait_sel | input | SEL_W (8) | Wait length in units of WAIT_UNIT_MS milliseconds |
| lamp | output | 1 | Indicator; high while the counter is running |
| count_bcd | output | 4*DIGITS (16) | Reaction time in milliseconds, in BCD |
| seg_n | output | 7*DISP_DIGITS (21) | Active-low segment patterns for the lowest digits |

## Verification
The bench runs with small divider values. It measures the exact edge on which the lamp lights, both for a non-zero wait and for a zero selector. An off-by-one in the wait comparison would light the lamp one millisecond early or late, or would never light it when the selector is zero. A stop press is sent during the wait and again after the count has stopped; a design that honoured either press would end the wait early or change the held result. The bench also presses arm and stop in the same cycle, and runs the counter past 9999 so that a wrapping design shows 0000.

// File: rtl/rt_pkg.sv
package rt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_COUNT = 2'd2,
    ST_DONE  = 2'd3
  } rt_state_e;

  localparam logic [6:0] SEG_ZERO  = 7'h40;
  localparam logic [6:0] SEG_BLANK = 7'h7F;

  // Active-low segment code, bit 0 = segment a, bit 6 = segment g
  function automatic logic [6:0] digit_to_seg_n(input logic [3:0] d);
    logic [6:0] s;
    case (d)
      4'd0: s = 7'h40;
      4'd1: s = 7'h79;
      4'd2: s = 7'h24;
      4'd3: s = 7'h30;
      4'd4: s = 7'h19;
      4'd5: s = 7'h12;
      4'd6: s = 7'h02;
      4'd7: s = 7'h78;
      4'd8: s = 7'h00;
      4'd9: s = 7'h10;
      default: s = SEG_BLANK;
    endcase
    return s;
  endfunction

  // Number of millisecond ticks the wait lasts
  function automatic int unsigned wait_ticks(input int unsigned sel,
                                             input int unsigned unit_ms);
    return sel * unit_ms;
  endfunction

  // Next value of one BCD digit given a carry in
  function automatic logic [3:0] bcd_step(input logic [3:0] d, input logic cin);
    logic [3:0] r;
    if (!cin)            r = d;
    else if (d == 4'd9)  r = 4'd0;
    else                 r = d + 4'd1;
    return r;
  endfunction

endpackage

// File: rtl/rt_tick_gen.sv
module rt_tick_gen #(
  parameter int DIV = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clear)      cnt_q <= '0;
    else if (run)        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + W'(1);
  end
endmodule

// File: rtl/rt_bcd_count.sv
module rt_bcd_count #(
  parameter int DIGITS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  inc,
  output logic [4*DIGITS-1:0]   q,
  output logic [4*DIGITS-1:0]   q_next
);
  logic [DIGITS-1:0] nine;
  logic [DIGITS-1:0] carry;
  logic              full;

  assign full     = &nine;
  assign carry[0] = inc && !full;

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    logic [3:0] cur;
    assign cur       = q[4*i +: 4];
    assign nine[i]   = (cur == 4'd9);
    assign q_next[4*i +: 4] = clear ? 4'd0 : rt_pkg::bcd_step(cur, carry[i]);
    if (i < DIGITS - 1) begin : g_carry
      assign carry[i+1] = carry[i] && nine[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end
endmodule

// File: rtl/rt_seg_bank.sv
module rt_seg_bank #(
  parameter int DISP = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [4*DISP-1:0]   digits,
  output logic [7*DISP-1:0]   seg_n
);
  for (genvar i = 0; i < DISP; i++) begin : g_seg
    logic [6:0] pat_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pat_q <= rt_pkg::SEG_ZERO;
      else        pat_q <= rt_pkg::digit_to_seg_n(digits[4*i +: 4]);
    end
    assign seg_n[7*i +: 7] = pat_q;
  end
endmodule

// File: rtl/reaction_timer.sv
module reaction_timer #(
  parameter int MS_DIV       = 50000,
  parameter int WAIT_UNIT_MS = 100,
  parameter int DIGITS       = 4,
  parameter int DISP_DIGITS  = 3,
  parameter int SEL_W        = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     arm_n,
  input  logic                     stop_n,
  input  logic [SEL_W-1:0]         wait_sel,
  output logic                     lamp,
  output logic [4*DIGITS-1:0]      count_bcd,
  output logic [7*DISP_DIGITS-1:0] seg_n
);
  import rt_pkg::*;

  localparam int MAX_WAIT = ((2 ** SEL_W) - 1) * WAIT_UNIT_MS;
  localparam int TW       = $clog2(MAX_WAIT + 1) + 1;

  rt_state_e state_q, state_d;

  // Named internal events
  logic arm_evt, stop_evt, run, ms_tick, wait_hit, count_inc;
  logic [TW-1:0] wait_ms_q, wait_goal;
  logic [4*DIGITS-1:0] count_next;
  logic lamp_q;

  assign arm_evt  = !arm_n;
  assign stop_evt = !stop_n;
  assign run      = (state_q == ST_WAIT) || (state_q == ST_COUNT);

  rt_tick_gen #(.DIV(MS_DIV)) u_ms_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (arm_evt),
    .run   (run),
    .tick  (ms_tick)
  );

  assign wait_goal = TW'(wait_ticks(32'(wait_sel), 32'(WAIT_UNIT_MS)));
  assign wait_hit  = (state_q == ST_WAIT) && ms_tick &&
                     ((wait_ms_q + TW'(1)) >= wait_goal);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wait_ms_q <= '0;
    else if (arm_evt)
      wait_ms_q <= '0;
    else if ((state_q == ST_WAIT) && ms_tick && !wait_hit)
      wait_ms_q <= wait_ms_q + TW'(1);
  end

  always_comb begin
    state_d = state_q;
    if (arm_evt) begin
      state_d = ST_WAIT;
    end else begin
      case (state_q)
        ST_WAIT:  if (wait_hit) state_d = ST_COUNT;
        ST_COUNT: if (stop_evt) state_d = ST_DONE;
        default:  state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lamp_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      lamp_q  <= (state_d == ST_COUNT);
    end
  end

  assign count_inc = (state_q == ST_COUNT) && !stop_evt && !arm_evt && ms_tick;

  rt_bcd_count #(.DIGITS(DIGITS)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (arm_evt),
    .inc    (count_inc),
    .q      (count_bcd),
    .q_next (count_next)
  );

  rt_seg_bank #(.DISP(DISP_DIGITS)) u_seg (
    .clk    (clk),
    .rst_n  (rst_n),
    .digits (count_next[4*DISP_DIGITS-1:0]),
    .seg_n  (seg_n)
  );

  assign lamp = lamp_q;

endmodule

// File: rtl/rt_checker.sv
module rt_checker #(
  parameter int DIGITS = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  arm_n,
  input logic                  stop_n,
  input logic                  lamp,
  input logic [4*DIGITS-1:0]   count_bcd,
  input rt_pkg::rt_state_e     state,
  input logic                  ms_tick,
  input logic                  wait_hit
);
  import rt_pkg::*;
  localparam logic [4*DIGITS-1:0] FULL = {DIGITS{4'h9}};

  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_n |=> (count_bcd == '0) && !lamp && (state == ST_WAIT)); // R2

  AST_LAMP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lamp) |-> $past(ms_tick) && ($past(state) == ST_WAIT)); // R3

  AST_WAIT_IGNORES_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) && arm_n && !wait_hit |=> (state == ST_WAIT) && !lamp); // R4

  AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COUNT) && arm_n && stop_n && ms_tick && (count_bcd != FULL)
      |=> count_bcd != $past(count_bcd)); // R5

  AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COUNT) && arm_n && !stop_n |=> !lamp && $stable(count_bcd)); // R6

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) && arm_n |=> (state == ST_DONE) && $stable(count_bcd) && !lamp); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (count_bcd == FULL) && arm_n |=> count_bcd == FULL); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) && arm_n |=> (state == ST_IDLE) && !lamp && (count_bcd == '0)); // R11

endmodule

bind reaction_timer rt_checker #(.DIGITS(DIGITS)) u_rt_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .arm_n     (arm_n),
  .stop_n    (stop_n),
  .lamp      (lamp),
  .count_bcd (count_bcd),
  .state     (state_q),
  .ms_tick   (ms_tick),
  .wait_hit  (wait_hit)
);

// File: tb/reaction_timer_test.sv
module reaction_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int MS_DIV  = 4;
  localparam int UNIT    = 3;
  localparam int DIGITS  = 4;
  localparam int DISP    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm_n = 1'b1;
  logic stop_n = 1'b1;
  logic [7:0] wait_sel = 8'd0;
  logic lamp;
  logic [4*DIGITS-1:0] count_bcd;
  logic [7*DISP-1:0] seg_n;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";

  reaction_timer #(.MS_DIV(MS_DIV), .WAIT_UNIT_MS(UNIT), .DIGITS(DIGITS),
                   .DISP_DIGITS(DISP), .SEL_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .arm_n(arm_n), .stop_n(stop_n),
    .wait_sel(wait_sel), .lamp(lamp), .count_bcd(count_bcd), .seg_n(seg_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference ----------------
  int m_phase = 0;   // 0 idle, 1 waiting, 2 lit, 3 stopped
  int m_pres  = 0;
  int m_ms    = 0;
  int m_val   = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_pres = 0; m_ms = 0; m_val = 0;
    end else if (!arm_n) begin
      m_phase = 1; m_pres = 0; m_ms = 0; m_val = 0;
    end else if (m_phase == 1 || m_phase == 2) begin
      bit tk;
      tk = (m_pres == MS_DIV - 1);
      m_pres = tk ? 0 : m_pres + 1;
      if (m_phase == 1) begin
        if (tk) begin
          m_ms++;
          if (m_ms >= ((int'(wait_sel) * UNIT > 1) ? int'(wait_sel) * UNIT : 1)) m_phase = 2;
        end
      end else begin
        if (!stop_n) m_phase = 3;
        else if (tk && m_val < 9999) m_val++;
      end
    end
  end

  function automatic logic [15:0] to_bcd(int v);
    logic [15:0] r;
    int x = v;
    for (int i = 0; i < 4; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  function automatic logic [6:0] seg_of(int d);
    case (d)
      0: return 7'h40; 1: return 7'h79; 2: return 7'h24; 3: return 7'h30;
      4: return 7'h19; 5: return 7'h12; 6: return 7'h02; 7: return 7'h78;
      8: return 7'h00; default: return 7'h10;
    endcase
  endfunction

  function automatic logic [7*DISP-1:0] segs_of(int v);
    logic [7*DISP-1:0] r;
    int x = v;
    for (int i = 0; i < DISP; i++) begin
      r[7*i +: 7] = seg_of(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    check(cur_req, "lamp", 32'(lamp), 32'(m_phase == 2));
    check(cur_req, "count", 32'(count_bcd), 32'(to_bcd(m_val)));
    check("R9", "segments", 32'(seg_n), 32'(segs_of(m_val)));
  end

  task automatic pulse_arm();
    arm_n = 1'b0;
    @(negedge clk);
    arm_n = 1'b1;
  endtask

  task automatic pulse_stop();
    stop_n = 1'b0;
    @(negedge clk);
    stop_n = 1'b1;
  endtask

  task automatic wait_lamp(output int n, input bit poke_stop);
    n = 0;
    for (int k = 1; k <= 4000; k++) begin
      @(negedge clk);
      if (poke_stop && k == 5) stop_n = 1'b0;
      if (poke_stop && k == 6) stop_n = 1'b1;
      if (lamp) begin
        n = k;
        break;
      end
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    int n;
    logic [15:0] held;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", "reset lamp", 32'(lamp), 0);
    check("R1", "reset count", 32'(count_bcd), 0);
    check("R1", "reset segs", 32'(seg_n), 32'({7'h40, 7'h40, 7'h40}));
    rst_n = 1'b1;

    // R11 idle ignores stop
    cur_req = "R11";
    pulse_stop();
    repeat (8) @(negedge clk);
    check("R11", "idle lamp", 32'(lamp), 0);
    check("R11", "idle count", 32'(count_bcd), 0);

    // R3 + R4 timed wait with stop poked during it
    cur_req = "R3";
    wait_sel = 8'd2;
    pulse_arm();
    wait_lamp(n, 1'b1);
    check("R4", "lamp edge with stop in wait", 32'(n), 32'(2 * UNIT * MS_DIV));

    // R5, R10 counting and carry
    cur_req = "R5";
    repeat (12 * MS_DIV) @(negedge clk);
    check("R5", "count after 12 ms", 32'(count_bcd), 32'h0012);
    check("R10", "carry into tens", 32'(count_bcd[7:4]), 1);
    check("R9", "segs show 012", 32'(seg_n), 32'({7'h40, 7'h79, 7'h24}));

    // R6 stop freezes
    cur_req = "R6";
    pulse_stop();
    check("R6", "lamp off after stop", 32'(lamp), 0);
    held = count_bcd;
    check("R6", "count frozen", 32'(count_bcd), 32'h0012);

    // R7 held through time and extra stops
    cur_req = "R7";
    repeat (20) @(negedge clk);
    pulse_stop();
    repeat (5) @(negedge clk);
    check("R7", "held after extra stop", 32'(count_bcd), 32'(held));
    check("R7", "lamp stays off", 32'(lamp), 0);

    // R2 arm clears, R3 zero selector
    cur_req = "R2";
    wait_sel = 8'd0;
    pulse_arm();
    check("R2", "arm clears count", 32'(count_bcd), 0);
    check("R2", "arm lamp off", 32'(lamp), 0);
    cur_req = "R3";
    wait_lamp(n, 1'b0);
    check("R3", "zero selector lamp edge", 32'(n), 32'(MS_DIV));

    // R2 arm wins over simultaneous stop
    cur_req = "R2";
    repeat (10) @(negedge clk);
    arm_n = 1'b0; stop_n = 1'b0;
    @(negedge clk);
    arm_n = 1'b1; stop_n = 1'b1;
    check("R2", "arm priority count", 32'(count_bcd), 0);
    check("R2", "arm priority lamp", 32'(lamp), 0);

    // R8 saturation
    cur_req = "R8";
    wait_lamp(n, 1'b0);
    repeat (10000 * MS_DIV + 20) @(negedge clk);
    check("R8", "saturated count", 32'(count_bcd), 32'h9999);
    check("R9", "segs show 999", 32'(seg_n), 32'({7'h10, 7'h10, 7'h10}));
    repeat (4 * MS_DIV) @(negedge clk);
    check("R8", "still saturated", 32'(count_bcd), 32'h9999);
    check("R8", "lamp still on", 32'(lamp), 1);
    cur_req = "R6";
    pulse_stop();
    check("R6", "stop after saturation", 32'(lamp), 0);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule